// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Lock

This block is a 32-bit down-counting watchdog peripheral that sits on a simple memory-mapped register bus. Software programs a reload value and turns on counting. The software must then service the watchdog regularly. When the count runs out once, the block raises an interrupt and starts a second count from the reload value. If the interrupt has still not been serviced when the second count runs out, and resets are enabled, the block asserts a system reset request.

Servicing is done by writing any value to the interrupt-clear word. That write drops the pending interrupt and restarts the count from the reload value. A magic key guards the load, control and interrupt-clear registers against stray writes. Writing the key to the lock word opens these registers, and writing any other value to the lock word closes them again.

All logic runs on the bus clock, and the reset is synchronous and active high. A read returns its data one clock after the read strobe. The returned data is the register state as it stood before that clock edge.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the load and current-value registers both read 0xFFFFFFFF, the control, raw status, masked status and lock registers all read 0, and both `irq_o` and `rst_req_o` are low.
- R2: Writing 0x1ACCE551 to byte offset 0xC00 unlocks the block, and writing any other value there locks it. A read of 0xC00 returns 1 while locked and 0 while unlocked. Writes to 0xC00 are always accepted.
- R3: While the block is locked, writes to load (0x000), control (0x008) and interrupt clear (0x00C) leave every register and output unchanged.
- R4: An accepted write to load sets both the load register and the current value to the written data at the same clock edge. Writing 0 to load while control bits 1:0 are both set leads to `rst_req_o` being high two clocks later.
- R5: Control bit 0 is the interrupt enable. While it is set, the current value (read at 0x004) decreases by one on every clock. While it is clear, the current value holds.
- R6: On a clock where the interrupt enable is set and the current value is 0, the current value is reloaded from load. If no interrupt is pending, the raw interrupt becomes pending. The expiry period is therefore load+1 clocks.
- R7: An expiry that finds the interrupt already pending, while control bit 1 (reset enable) is set, raises `rst_req_o`. From a fresh restart at value V, this happens V+L+2 clocks later, where L is the load value. If reset enable is clear, expiries never raise `rst_req_o`.
- R8: An accepted write of any data to interrupt clear (0x00C) clears the pending interrupt and reloads the current value from load.
- R9: Bit 0 of the raw status word (0x010) shows the pending interrupt whatever the enables are. Bit 0 of the masked status word (0x014) and `irq_o` both equal the raw status ANDed with the interrupt enable.
- R10: Writing 0 to control stops counting and drives `irq_o` and `rst_req_o` low. Any accepted control write with bit 1 clear drops the reset request.
- R11: `rdata` changes only on the clock after `rd_en`. It reads 0 for interrupt clear, for unmapped offsets, and on clocks without a read. Control reads return only bits 1:0.
- R12: An accepted load or interrupt-clear write on the same clock as an expiry takes precedence. No interrupt is set and no reset is raised on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe, one clock per read |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| irq_o | output | 1 | Interrupt request (pending AND interrupt enable) |
| rst_req_o | output | 1 | System reset request |

## Verification
The hardest situation to reach from the ports is a service write that lands on exactly the clock on which the count hits zero. This case decides whether the interrupt is set and whether a reset escalates. A directed sequence reaches it by loading a small value with counting already on, then idling a known number of clocks so that the clear meets the zero clock exactly. The lock must also be exercised with an interrupt already pending, so that an ignored clear stays visible in the raw status. Random traffic with small load values then keeps expiries, clears, control changes and lock toggling colliding at many offsets. A cycle-level model in the bench tracks every collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Byte offsets of the register words
  localparam logic [11:0] OFS_LOAD   = 12'h000;
  localparam logic [11:0] OFS_VALUE  = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam logic [11:0] OFS_ICLR   = 12'h00C;
  localparam logic [11:0] OFS_RAW    = 12'h010;
  localparam logic [11:0] OFS_MASKED = 12'h014;
  localparam logic [11:0] OFS_LOCK   = 12'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  localparam int IE_BIT = 0;
  localparam int RE_BIT = 1;

  typedef struct packed {
    logic load;   // accepted load write
    logic iclr;   // accepted interrupt clear write
    logic ctrl;   // accepted control write
  } wr_strobe_t;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [DATA_W-1:0]        load_val,
  input  logic [DATA_W-1:0]        cur_val,
  input  logic                     raw_irq,
  output wdog_pkg::wr_strobe_t     stb,
  output logic [1:0]               ctrl,
  output logic                     locked,
  output logic [DATA_W-1:0]        rdata
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ICLR   = ADDR_W'(OFS_ICLR);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFS_LOCK);
  localparam logic [DATA_W-1:0] KEY      = DATA_W'(UNLOCK_KEY);

  logic              locked_q;
  logic [1:0]        ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              open_wr;
  logic              lock_wr;

  assign open_wr  = wr_en && !locked_q;
  assign lock_wr  = wr_en && (addr == A_LOCK);
  assign stb.load = open_wr && (addr == A_LOAD);
  assign stb.iclr = open_wr && (addr == A_ICLR);
  assign stb.ctrl = open_wr && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      ctrl_q   <= 2'b00;
    end else begin
      if (lock_wr)
        locked_q <= (wdata != KEY);
      if (stb.ctrl)
        ctrl_q <= wdata[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_LOAD:   rd_mux = load_val;
      A_VALUE:  rd_mux = cur_val;
      A_CTRL:   rd_mux = {{(DATA_W-2){1'b0}}, ctrl_q};
      A_RAW:    rd_mux = {{(DATA_W-1){1'b0}}, raw_irq};
      A_MASKED: rd_mux = {{(DATA_W-1){1'b0}}, raw_irq & ctrl_q[IE_BIT]};
      A_LOCK:   rd_mux = {{(DATA_W-1){1'b0}}, locked_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? rd_mux : '0;
  end

  assign ctrl   = ctrl_q;
  assign locked = locked_q;
  assign rdata  = rdata_q;

  // R2
  lock_key_chk: assert property (@(posedge clk) disable iff (rst)
    lock_wr |=> (locked_q == ($past(wdata) != KEY)));

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata_q == '0));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic              clr_stb,
  input  logic              rst_drop,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ie,
  input  logic              re,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cur_val,
  output logic              raw_irq,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] value_q;
  logic              raw_q;
  logic              rst_q;
  logic              at_zero;
  logic              expire;

  assign at_zero = (value_q == '0);
  assign expire  = ie && at_zero && !ld_stb && !clr_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= ALL_ONES;
      value_q <= ALL_ONES;
    end else if (ld_stb) begin
      load_q  <= wdata;
      value_q <= wdata;
    end else if (clr_stb || expire) begin
      value_q <= load_q;
    end else if (ie) begin
      value_q <= value_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  raw_q <= 1'b0;
    else if (clr_stb)         raw_q <= 1'b0;
    else if (expire)          raw_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                          rst_q <= 1'b0;
    else if (rst_drop)                rst_q <= 1'b0;
    else if (expire && raw_q && re)   rst_q <= 1'b1;
  end

  assign load_val = load_q;
  assign cur_val  = value_q;
  assign raw_irq  = raw_q;
  assign rst_req  = rst_q;

  // R4
  load_reload_chk: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> (value_q == $past(wdata) && load_q == $past(wdata)));

  // R8
  clear_reload_chk: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> (!raw_q && value_q == $past(load_q)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie && !ld_stb && !clr_stb) |=> $stable(value_q));

  // R7
  escalate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_q) |-> ($past(raw_q) && $past(re)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);

  wr_strobe_t        stb;
  logic [1:0]        ctrl;
  logic              locked;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] cur_val;
  logic              raw_irq;
  logic              rst_req;
  logic              rst_drop;

  assign rst_drop = stb.ctrl && !wdata[RE_BIT];

  wdog_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .load_val (load_val),
    .cur_val  (cur_val),
    .raw_irq  (raw_irq),
    .stb      (stb),
    .ctrl     (ctrl),
    .locked   (locked),
    .rdata    (rdata)
  );

  wdog_count #(.DATA_W(DATA_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .ld_stb   (stb.load),
    .clr_stb  (stb.iclr),
    .rst_drop (rst_drop),
    .wdata    (wdata),
    .ie       (ctrl[IE_BIT]),
    .re       (ctrl[RE_BIT]),
    .load_val (load_val),
    .cur_val  (cur_val),
    .raw_irq  (raw_irq),
    .rst_req  (rst_req)
  );

  assign irq_o     = raw_irq & ctrl[IE_BIT];
  assign rst_req_o = rst_req;

  // R3
  locked_load_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && addr == A_LOAD) |=> $stable(load_val));

  // R10
  ctrl_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 2'b00) |-> !rst_req_o);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [31:0] m_load, m_val, m_rdata;
  logic [1:0]  m_ctrl;
  logic        m_raw, m_rst, m_locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_val;
      12'h008: return {30'b0, m_ctrl};
      12'h010: return {31'b0, m_raw};
      12'h014: return {31'b0, m_raw & m_ctrl[0]};
      12'hC00: return {31'b0, m_locked};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [11:0] a);
    case (a)
      12'h000: return "R4 load read";
      12'h004: return "R5 value read";
      12'h008: return "R10 ctrl read";
      12'h010: return "R9 raw read";
      12'h014: return "R9 masked read";
      12'hC00: return "R2 lock read";
      default: return "R11 zero read";
    endcase
  endfunction

  task automatic model_reset();
    m_load = 32'hFFFFFFFF; m_val = 32'hFFFFFFFF; m_ctrl = 2'b00;
    m_raw = 1'b0; m_rst = 1'b0; m_locked = 1'b0; m_rdata = '0;
  endtask

  task automatic model_step(bit wr, bit rd, logic [11:0] a, logic [31:0] d);
    logic [31:0] nload, nval;
    logic [1:0]  nctrl;
    logic        nraw, nrst, nlocked;
    bit open, ld, clr, cw;
    nload = m_load; nval = m_val; nctrl = m_ctrl;
    nraw = m_raw; nrst = m_rst; nlocked = m_locked;
    m_rdata = rd ? model_read(a) : 32'h0;
    open = wr && !m_locked;
    ld   = open && a == 12'h000;
    clr  = open && a == 12'h00C;
    cw   = open && a == 12'h008;
    if (ld) begin
      nload = d; nval = d;
    end else if (clr) begin
      nval = m_load; nraw = 1'b0;
    end else if (m_ctrl[0]) begin
      if (m_val == 0) begin
        nval = m_load;
        if (m_raw) begin
          if (m_ctrl[1]) nrst = 1'b1;
        end else nraw = 1'b1;
      end else nval = m_val - 1;
    end
    if (cw) begin
      nctrl = d[1:0];
      if (!d[1]) nrst = 1'b0;
    end
    if (wr && a == 12'hC00) nlocked = (d != KEY);
    m_load = nload; m_val = nval; m_ctrl = nctrl;
    m_raw = nraw; m_rst = nrst; m_locked = nlocked;
  endtask

  // one bus clock: drive at negedge, model at posedge, check after it
  task automatic cycle(bit wr, bit rd, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(posedge clk);
    model_step(wr, rd, a, d);
    #1;
    chk("R9 irq_o", {31'b0, irq_o}, {31'b0, m_raw & m_ctrl[0]});
    chk("R7 rst_req_o", {31'b0, rst_req_o}, {31'b0, m_rst});
    if (rd) chk(read_tag(a), rdata, m_rdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cycle(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
    cycle(1'b0, 1'b1, a, 32'h0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 rst_req_o after reset", {31'b0, rst_req_o}, 32'h0);

    // R1 / R11 reset state reads
    rd_expect(12'h000, 32'hFFFFFFFF, "R1 load");
    rd_expect(12'h004, 32'hFFFFFFFF, "R1 value");
    rd_expect(12'h008, 32'h0, "R1 ctrl");
    rd_expect(12'h010, 32'h0, "R1 raw");
    rd_expect(12'h014, 32'h0, "R1 masked");
    rd_expect(12'hC00, 32'h0, "R1 lock");
    rd_expect(12'h00C, 32'h0, "R11 iclr reads zero");
    rd_expect(12'h040, 32'h0, "R11 unmapped reads zero");

    // R4 load write, R5 hold while disabled
    wr(12'h000, 32'd5);
    rd_expect(12'h004, 32'd5, "R4 value after load");
    idle(3);
    rd_expect(12'h004, 32'd5, "R5 hold when disabled");

    // R5 / R6 counting and first expiry
    wr(12'h008, 32'd1);
    rd_expect(12'h004, 32'd5, "R5 first count edge");
    rd_expect(12'h004, 32'd4, "R5 decrement");
    idle(3);
    rd_expect(12'h004, 32'd0, "R6 reached zero");
    chk("R6 irq after expiry", {31'b0, irq_o}, 32'h1);
    rd_expect(12'h010, 32'h1, "R9 raw set");
    idle(20);
    chk("R7 no reset when reset enable clear", {31'b0, rst_req_o}, 32'h0);

    // R8 keep-alive
    wr(12'h00C, 32'hDEAD);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    rd_expect(12'h004, 32'd5, "R8 value reloaded");

    // R12 clear on the zero clock, then R7 timing V+L+2
    wr(12'h008, 32'd0);
    wr(12'h008, 32'd3);
    wr(12'h000, 32'd2);
    idle(2);
    wr(12'h00C, 32'h0);
    chk("R12 clear wins over expiry", {31'b0, irq_o}, 32'h0);
    idle(5);
    chk("R7 no reset before V+L+2", {31'b0, rst_req_o}, 32'h0);
    chk("R6 irq at first expiry", {31'b0, irq_o}, 32'h1);
    idle(1);
    chk("R7 reset at V+L+2", {31'b0, rst_req_o}, 32'h1);

    // R10 control off
    wr(12'h008, 32'd0);
    chk("R10 reset dropped", {31'b0, rst_req_o}, 32'h0);
    chk("R10 irq dropped", {31'b0, irq_o}, 32'h0);
    rd_expect(12'h010, 32'h1, "R9 raw kept without enable");
    rd_expect(12'h014, 32'h0, "R9 masked zero without enable");

    // R2 / R3 lock
    wr(12'hC00, 32'd1);
    rd_expect(12'hC00, 32'h1, "R2 locked reads 1");
    wr(12'h00C, 32'h0);
    rd_expect(12'h010, 32'h1, "R3 clear ignored while locked");
    wr(12'h000, 32'd7);
    rd_expect(12'h000, 32'd2, "R3 load ignored while locked");
    wr(12'h008, 32'd3);
    rd_expect(12'h008, 32'h0, "R3 ctrl ignored while locked");
    wr(12'hC00, KEY);
    rd_expect(12'hC00, 32'h0, "R2 key unlocks");
    wr(12'hC00, KEY ^ 32'h1);
    rd_expect(12'hC00, 32'h1, "R2 near-key locks");
    wr(12'hC00, KEY);

    // R4 load of zero with both enables
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'd3);
    wr(12'h000, 32'd0);
    idle(1);
    chk("R4 zero load no reset yet", {31'b0, rst_req_o}, 32'h0);
    idle(1);
    chk("R4 zero load reset", {31'b0, rst_req_o}, 32'h1);
    wr(12'h008, 32'd0);

    // random traffic checked against the model
    for (int n = 0; n < 6000; n++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 45) idle(1);
      else if (sel < 65) begin
        logic [11:0] ra;
        case ($urandom_range(0, 7))
          0: ra = 12'h000; 1: ra = 12'h004; 2: ra = 12'h008; 3: ra = 12'h00C;
          4: ra = 12'h010; 5: ra = 12'h014; 6: ra = 12'hC00; default: ra = 12'h018;
        endcase
        cycle(1'b0, 1'b1, ra, 32'h0);
      end
      else if (sel < 74) wr(12'h000, 32'($urandom_range(0, 12)));
      else if (sel < 84) wr(12'h00C, $urandom);
      else if (sel < 92) wr(12'h008, 32'($urandom_range(0, 3)));
      else if (sel < 96) wr(12'hC00, KEY);
      else wr(12'hC00, $urandom_range(0, 3));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule